// File: doc/BRIEF.md
# Symmetric PWM Generator with Zero-Committed Action Settings

This block drives a pair of PWM outputs from one time-base counter that climbs from zero to a programmable peak and then descends back to zero, which gives centre-aligned waveforms. Each output has its own compare level and its own set of output actions. An action is applied when the counter reaches zero, when it meets the compare level while rising, and when it meets the level while falling. Each action can force the pin low, force it high, invert it, or leave it alone.

Software programs the period, the two compare levels and the two action sets through a simple write port. These writes land in shadow copies. The whole set moves into the working copies on the clock where the counter is at zero. A control routine can therefore change the duty cycle or the whole polarity scheme at any moment without cutting a period short. The working copies can be read back at any time.

A sync strobe can reload the counter from a phase input and choose the direction it moves afterwards. A one-clock interrupt pulse marks every zero of the counter.

Top module: `sym_pwm`

## Requirements
- R1: While reset is held, the counter is 0, both PWM pins and the interrupt are low, the working period reads as RST_PERIOD (default 5000), and the working compare levels, action sets and control bits read as 0.
- R2: With a working period P > 0 and no sync, the counter steps by one per clock in the order 0, 1, ..., P, P-1, ..., 1, 0. A full period is 2P clocks.
- R3: Writes use wrAddr 0 = period, 1 = compare A, 2 = compare B, 3 = action set A, 4 = action set B, 5 = control. The same numbers on rdAddr read the working copies. Period, compares and action sets written at other times than the zero count stay invisible until the clock edge that ends a cycle in which the counter is 0. There they are all copied to the working copies together. Control writes take effect on the next edge.
- R4: An action set is 6 bits: bits [1:0] act at zero, bits [3:2] at a rising match, bits [5:4] at a falling match. Code 0 holds the pin, 1 drives it low, 2 drives it high, 3 inverts it. The pin changes on the edge that ends the cycle in which the counter shows the event count.
- R5: Pin A is driven only by compare level A and action set A. Pin B is driven only by compare level B and action set B.
- R6: A match at the peak count P is treated as a falling match. A match at any count below P while rising is a rising match.
- R7: When the zero event coincides with a compare match, only the zero action is applied.
- R8: In the cycle where the counter is 0 and a commit occurs, the zero action and matches are evaluated with the values being committed.
- R9: zeroIrq is high for exactly the one clock that follows each cycle in which the counter is 0.
- R10: With control bit 0 set, a syncIn pulse loads phaseVal into the counter on the next edge. Control bit 1 then picks the direction (1 = rising, 0 = falling). With control bit 0 clear, syncIn has no effect.
- R11: A compare level of 0 with the zero action high gives a constant high pin. A compare level equal to P gives a constant pin under both the pattern "zero high, rise low, fall high" and the pattern "zero low, rise high, fall low".

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | CNT_W | Register write data |
| rdAddr | input | 3 | Working-copy read address |
| rdData | output | CNT_W | Working-copy read data |
| phaseVal | input | CNT_W | Value loaded into the counter on sync |
| syncIn | input | 1 | Sync strobe |
| pwmA | output | 1 | PWM output A |
| pwmB | output | 1 | PWM output B |
| cntOut | output | CNT_W | Current counter value |
| zeroIrq | output | 1 | One-clock pulse after each zero count |

## Verification
The hardest case to reach is a change of configuration that lands partway through a period. The old settings must keep governing the pin up to the zero, and the new zero action must already apply at that zero. The bench waits until the counter is partway up a rising slope, rewrites the compare level and action set there, and reads the working copies on both sides of the zero. It checks the pin in the cycle just before the commit and in the cycle just after, choosing old and new zero actions with opposite results. Coinciding zero and compare events, and peak matches, are reached by placing the compare level at 0 or at the period in the stimulus table.

// File: rtl/sym_pwm_pkg.sv
package sym_pwm_pkg;

  typedef enum logic [1:0] {
    AQ_HOLD = 2'd0,
    AQ_LOW  = 2'd1,
    AQ_HIGH = 2'd2,
    AQ_FLIP = 2'd3
  } aqCode_t;

  // zero action in the low bits, falling-match action in the high bits
  typedef struct packed {
    aqCode_t onDown;
    aqCode_t onUp;
    aqCode_t onZero;
  } aqSet_t;

  // strobes from the time base to the datapath
  typedef struct packed {
    logic atZero;
    logic classUp;
    logic classDown;
  } tbStrobe_t;

  localparam int AQ_W   = $bits(aqSet_t);
  localparam int NUM_CH = 2;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMPA   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMPB   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_AQA    = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_AQB    = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd5;

  function automatic logic aqApply(input logic cur, input aqCode_t code);
    case (code)
      AQ_LOW:  return 1'b0;
      AQ_HIGH: return 1'b1;
      AQ_FLIP: return ~cur;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/sym_pwm_timebase.sv
module sym_pwm_timebase
  import sym_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] shPeriod,
  input  logic [CNT_W-1:0] actPeriod,
  input  logic             phaseEn,
  input  logic             syncDirUp,
  input  logic             syncIn,
  input  logic [CNT_W-1:0] phaseVal,
  output logic [CNT_W-1:0] cnt,
  output tbStrobe_t        strobe,
  output logic             zeroIrq
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             dirUp;
  logic             atZero;
  logic [CNT_W-1:0] effPeriod;

  assign atZero    = (cnt == '0);
  // the period being committed governs the step out of zero
  assign effPeriod = atZero ? shPeriod : actPeriod;

  always_comb begin
    strobe.atZero    = atZero;
    strobe.classUp   = dirUp && (cnt < effPeriod);
    strobe.classDown = !(dirUp && (cnt < effPeriod));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      dirUp   <= 1'b1;
      zeroIrq <= 1'b0;
    end else begin
      zeroIrq <= atZero;
      if (syncIn && phaseEn) begin
        cnt   <= phaseVal;
        dirUp <= syncDirUp;
      end else if (effPeriod == '0) begin
        cnt   <= '0;
        dirUp <= 1'b1;
      end else if (dirUp) begin
        if (cnt >= effPeriod) begin
          cnt   <= cnt - ONE;
          dirUp <= 1'b0;
        end else begin
          cnt <= cnt + ONE;
        end
      end else begin
        if (atZero) begin
          cnt   <= ONE;
          dirUp <= 1'b1;
        end else begin
          cnt <= cnt - ONE;
        end
      end
    end
  end

endmodule

// File: rtl/sym_pwm_datapath.sv
module sym_pwm_datapath
  import sym_pwm_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int RST_PERIOD = 5000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [CNT_W-1:0]  cnt,
  input  tbStrobe_t         strobe,
  output logic [CNT_W-1:0]  shPeriod,
  output logic [CNT_W-1:0]  actPeriod,
  output logic [CNT_W-1:0]  actCmp [NUM_CH],
  output aqSet_t            actAq  [NUM_CH],
  output logic              phaseEn,
  output logic              syncDirUp,
  output logic [NUM_CH-1:0] pwmOut
);

  localparam logic [CNT_W-1:0] PERIOD_INIT = CNT_W'(RST_PERIOD);

  // period and control register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shPeriod  <= PERIOD_INIT;
      actPeriod <= PERIOD_INIT;
      phaseEn   <= 1'b0;
      syncDirUp <= 1'b0;
    end else begin
      if (wrEn && wrAddr == ADDR_PERIOD) shPeriod <= wrData;
      if (wrEn && wrAddr == ADDR_CTRL) begin
        phaseEn   <= wrData[0];
        syncDirUp <= wrData[1];
      end
      if (strobe.atZero) actPeriod <= shPeriod;
    end
  end

  // one compare level, one action set and one pin per channel
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [ADDR_W-1:0] CMP_ADDR = ADDR_CMPA + ADDR_W'(ch);
    localparam logic [ADDR_W-1:0] AQ_ADDR  = ADDR_AQA + ADDR_W'(ch);

    logic [CNT_W-1:0] shCmp;
    aqSet_t           shAq;
    logic [CNT_W-1:0] effCmp;
    aqSet_t           effAq;
    logic             hit;
    aqCode_t          code;

    assign effCmp = strobe.atZero ? shCmp : actCmp[ch];
    assign effAq  = strobe.atZero ? shAq : actAq[ch];
    assign hit    = (cnt == effCmp);

    // zero beats falling match beats rising match
    always_comb begin
      if (strobe.atZero)                code = effAq.onZero;
      else if (hit && strobe.classDown) code = effAq.onDown;
      else if (hit && strobe.classUp)   code = effAq.onUp;
      else                              code = AQ_HOLD;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        shCmp      <= '0;
        shAq       <= '0;
        actCmp[ch] <= '0;
        actAq[ch]  <= '0;
        pwmOut[ch] <= 1'b0;
      end else begin
        if (wrEn && wrAddr == CMP_ADDR) shCmp <= wrData;
        if (wrEn && wrAddr == AQ_ADDR)  shAq  <= aqSet_t'(wrData[AQ_W-1:0]);
        if (strobe.atZero) begin
          actCmp[ch] <= shCmp;
          actAq[ch]  <= shAq;
        end
        pwmOut[ch] <= aqApply(pwmOut[ch], code);
      end
    end
  end

endmodule

// File: rtl/sym_pwm.sv
module sym_pwm
  import sym_pwm_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int RST_PERIOD = 5000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [2:0]       rdAddr,
  output logic [CNT_W-1:0] rdData,
  input  logic [CNT_W-1:0] phaseVal,
  input  logic             syncIn,
  output logic             pwmA,
  output logic             pwmB,
  output logic [CNT_W-1:0] cntOut,
  output logic             zeroIrq
);

  logic [CNT_W-1:0]  shPeriod;
  logic [CNT_W-1:0]  actPeriod;
  logic [CNT_W-1:0]  actCmp [NUM_CH];
  aqSet_t            actAq  [NUM_CH];
  logic              phaseEn;
  logic              syncDirUp;
  logic [NUM_CH-1:0] pwmOut;
  tbStrobe_t         strobe;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  actCmpA, actCmpB;
  aqSet_t            actAqA, actAqB;

  sym_pwm_timebase #(.CNT_W(CNT_W)) tb_i (
    .clk(clk), .rstN(rstN), .shPeriod(shPeriod), .actPeriod(actPeriod),
    .phaseEn(phaseEn), .syncDirUp(syncDirUp), .syncIn(syncIn),
    .phaseVal(phaseVal), .cnt(cnt), .strobe(strobe), .zeroIrq(zeroIrq)
  );

  sym_pwm_datapath #(.CNT_W(CNT_W), .RST_PERIOD(RST_PERIOD)) dp_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cnt(cnt), .strobe(strobe), .shPeriod(shPeriod), .actPeriod(actPeriod),
    .actCmp(actCmp), .actAq(actAq), .phaseEn(phaseEn),
    .syncDirUp(syncDirUp), .pwmOut(pwmOut)
  );

  assign actCmpA = actCmp[0];
  assign actCmpB = actCmp[1];
  assign actAqA  = actAq[0];
  assign actAqB  = actAq[1];
  assign pwmA    = pwmOut[0];
  assign pwmB    = pwmOut[1];
  assign cntOut  = cnt;

  always_comb begin
    case (rdAddr)
      ADDR_PERIOD: rdData = actPeriod;
      ADDR_CMPA:   rdData = actCmpA;
      ADDR_CMPB:   rdData = actCmpB;
      ADDR_AQA:    rdData = CNT_W'(actAqA);
      ADDR_AQB:    rdData = CNT_W'(actAqB);
      ADDR_CTRL:   rdData = CNT_W'({syncDirUp, phaseEn});
      default:     rdData = '0;
    endcase
  end

endmodule

// File: rtl/sym_pwm_chk.sv
module sym_pwm_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] cntOut,
  input logic             syncIn,
  input logic             zeroIrq,
  input logic             pwmA,
  input logic             pwmB,
  input logic [CNT_W-1:0] actPeriod,
  input logic [CNT_W-1:0] actCmpA,
  input logic [CNT_W-1:0] actCmpB,
  input logic [5:0]       actAqA,
  input logic [5:0]       actAqB
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!syncIn && cntOut != '0 && cntOut < actPeriod) |=>
      (cntOut == $past(cntOut) + ONE || cntOut == $past(cntOut) - ONE)); // R2

  AST_COMMIT_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (cntOut != '0) |=> ($stable(actPeriod) && $stable(actCmpA) && $stable(actCmpB)
                        && $stable(actAqA) && $stable(actAqB))); // R3

  AST_IRQ_FOLLOWS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (cntOut == '0) |=> zeroIrq); // R9

  AST_IRQ_ONLY_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    zeroIrq |-> ($past(cntOut) == '0)); // R9

  AST_PWMA_ON_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pwmA) |-> ($past(cntOut) == '0 || $past(cntOut) == $past(actCmpA))); // R5

  AST_PWMB_ON_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pwmB) |-> ($past(cntOut) == '0 || $past(cntOut) == $past(actCmpB))); // R5

endmodule

bind sym_pwm sym_pwm_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .cntOut(cntOut), .syncIn(syncIn), .zeroIrq(zeroIrq),
  .pwmA(pwmA), .pwmB(pwmB), .actPeriod(actPeriod), .actCmpA(actCmpA),
  .actCmpB(actCmpB), .actAqA(actAqA), .actAqB(actAqB)
);

// File: tb/sym_pwm_tb.sv
module sym_pwm_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int P          = 8;
  localparam int NVEC       = 5;

  // row: cmpA, aqA, cmpB, aqB, expected high count A, B over 2P clocks
  localparam logic [47:0] VEC [NVEC] = '{
    48'h03_26_05_19_06_06,  // R4 R5 mid-range levels, both polarities
    48'h00_26_08_26_10_10,  // R11 zero level steady high, R6 peak level steady high
    48'h08_19_00_19_00_00,  // R6 R11 peak level steady low, R7 zero beats fall
    48'h00_21_06_26_00_0C,  // R7 zero-low beats fall-high at count 0
    48'h07_26_01_19_0E_0E   // R4 R5 near-edge levels
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic [2:0]       wrAddr = '0;
  logic [CNT_W-1:0] wrData = '0;
  logic [2:0]       rdAddr = '0;
  logic [CNT_W-1:0] rdData;
  logic [CNT_W-1:0] phaseVal = '0;
  logic             syncIn = 1'b0;
  logic             pwmA, pwmB, zeroIrq;
  logic [CNT_W-1:0] cntOut;

  int nChecks = 0;
  int nFail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sym_pwm #(.CNT_W(CNT_W), .RST_PERIOD(5000)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .phaseVal(phaseVal), .syncIn(syncIn),
    .pwmA(pwmA), .pwmB(pwmB), .cntOut(cntOut), .zeroIrq(zeroIrq)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    wrEn = 1'b1; wrAddr = a; wrData = CNT_W'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    rdAddr = a;
    #1;
    d = int'(rdData);
  endtask

  task automatic waitZero();
    do @(negedge clk); while (cntOut !== '0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++; nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    int v, v1, hiA, hiB, cnt1;
    repeat (3) @(negedge clk);
    // reset state
    check("R1 counter", int'(cntOut), 0);
    check("R1 pwmA", int'(pwmA), 0);
    check("R1 pwmB", int'(pwmB), 0);
    check("R1 irq", int'(zeroIrq), 0);
    rd(3'd0, v); check("R1 period", v, 5000);
    rd(3'd1, v); check("R1 cmpA", v, 0);
    rd(3'd3, v); check("R1 aqA", v, 0);
    rd(3'd5, v); check("R1 ctrl", v, 0);
    rstN = 1'b1;
    @(negedge clk);

    // shadowed period
    wr(3'd0, P);
    rd(3'd0, v); check("R3 period held before zero", v, 5000);
    waitZero();
    rd(3'd0, v); check("R3 period held in zero cycle", v, 5000);
    check("R9 irq low in zero cycle", int'(zeroIrq), 0);
    @(negedge clk);
    rd(3'd0, v); check("R3 period committed", v, P);
    check("R9 irq after zero", int'(zeroIrq), 1);
    check("R2 first step", int'(cntOut), 1);
    @(negedge clk);
    check("R9 irq one clock", int'(zeroIrq), 0);

    // counter sweep and irq count
    waitZero();
    cnt1 = 0;
    for (int k = 1; k <= 2*P; k++) begin
      @(negedge clk);
      check($sformatf("R2 count step %0d", k), int'(cntOut), (k <= P) ? k : 2*P - k);
      if (zeroIrq) cnt1++;
    end
    check("R9 irq pulses per period", cnt1, 1);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      wr(3'd1, int'(VEC[i][47:40]));
      wr(3'd3, int'(VEC[i][39:32]));
      wr(3'd2, int'(VEC[i][31:24]));
      wr(3'd4, int'(VEC[i][23:16]));
      waitZero();
      waitZero();
      hiA = 0; hiB = 0;
      for (int k = 0; k < 2*P; k++) begin
        if (k != 0) @(negedge clk);
        hiA += int'(pwmA);
        hiB += int'(pwmB);
      end
      check($sformatf("R4 R5 R6 R7 R11 row %0d pwmA high", i), hiA, int'(VEC[i][15:8]));
      check($sformatf("R4 R5 R6 R7 R11 row %0d pwmB high", i), hiB, int'(VEC[i][7:0]));
    end

    // mid-period change commits only at zero, zero uses new values
    wr(3'd1, 3);
    wr(3'd3, 'h26);
    waitZero();
    waitZero();
    repeat (5) @(negedge clk);
    wr(3'd3, 'h19);
    wr(3'd1, 5);
    rd(3'd3, v); check("R3 aqA held mid-period", v, 'h26);
    rd(3'd1, v); check("R3 cmpA held mid-period", v, 3);
    waitZero();
    rd(3'd3, v); check("R3 aqA held in zero cycle", v, 'h26);
    check("R3 old actions rule until zero", int'(pwmA), 1);
    @(negedge clk);
    check("R8 new zero action at commit", int'(pwmA), 0);
    rd(3'd3, v); check("R3 aqA committed", v, 'h19);
    rd(3'd1, v); check("R3 cmpA committed", v, 5);

    // toggle at zero
    wr(3'd3, 'h03);
    waitZero();
    waitZero();
    @(negedge clk);
    v1 = int'(pwmA);
    waitZero();
    @(negedge clk);
    check("R4 toggle flips each period", int'(pwmA), 1 - v1);

    // hold code keeps pin frozen
    wr(3'd4, 'h00);
    waitZero();
    waitZero();
    v1 = int'(pwmB);
    cnt1 = 0;
    for (int k = 0; k < 2*P; k++) begin
      @(negedge clk);
      if (int'(pwmB) != v1) cnt1++;
    end
    check("R4 hold code pin changes", cnt1, 0);

    // sync ignored without phase enable
    phaseVal = 16'd5;
    waitZero();
    syncIn = 1'b1;
    @(negedge clk);
    syncIn = 1'b0;
    check("R10 sync ignored when disabled", int'(cntOut), 1);

    // sync with phase load, falling
    wr(3'd5, 1);
    waitZero();
    syncIn = 1'b1;
    @(negedge clk);
    syncIn = 1'b0;
    check("R10 phase loaded", int'(cntOut), 5);
    @(negedge clk);
    check("R10 falling after sync", int'(cntOut), 4);

    // sync with phase load, rising
    wr(3'd5, 3);
    waitZero();
    syncIn = 1'b1;
    @(negedge clk);
    syncIn = 1'b0;
    check("R10 phase loaded rising", int'(cntOut), 5);
    @(negedge clk);
    check("R10 rising after sync", int'(cntOut), 6);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule